// File: doc/BRIEF.md
# DMA Transfer Alignment Splitter

This block turns one memory-to-memory copy request into a short sequence of copy descriptors, chosen so that the DMA engine can run most of the data with its widest burst. A request gives a start address and a byte count. Both must be multiples of 4. The block hands out descriptors in address order.

- A leading piece runs up to the first 32-byte boundary and uses 4-byte accesses.
- A middle piece is 32-byte aligned, is a whole number of 32-byte blocks, and uses 32-byte accesses.
- A trailing remainder uses 4-byte accesses.

Pieces of zero length are never issued. A request whose alignment is illegal raises an error pulse and produces nothing.

Descriptors leave over a valid/ready handshake. Each one carries an address, a byte count, an access-size code and a flag that marks the final descriptor of the request. The block accepts a new request only when it is idle. It sits between a request source, such as a software copy queue, and the DMA engine's descriptor input.

Top module: `dma_align_splitter`

## Requirements
- R1: After reset, `seg_valid` and `req_err` are 0 and `req_ready` is 1.
- R2: A request is illegal when address bits [1:0] are nonzero, or count bits [1:0] are nonzero, or the count is zero. An illegal request that is accepted drives `req_err` to 1 for exactly the one cycle after acceptance. It produces no descriptor, and `req_ready` stays 1.
- R3: The leading descriptor starts at the request address and ends at the first 32-byte boundary above it. Its `seg_size` is 2, where the code means 2^code bytes per access. It is issued only when the address is not already 32-byte aligned.
- R4: The middle descriptor has address bits [4:0] equal to 0, a count that is a nonzero multiple of 32, and `seg_size` 5.
- R5: The trailing descriptor carries the leftover count after the middle piece, between 4 and 28 bytes, with `seg_size` 2. It is issued only when that leftover is nonzero.
- R6: When the count is no larger than the distance to the first 32-byte boundary, exactly one descriptor is issued. It covers the whole request with `seg_size` 2.
- R7: `seg_last` is 1 on the final descriptor of a request and 0 on every earlier one. After the final descriptor is taken, `seg_valid` falls and `req_ready` returns to 1 on the next cycle.
- R8: The counts of a request's descriptors add up to the request count. Each descriptor starts where the previous one ended.
- R9: While `seg_valid` is 1 and `seg_ready` is 0, every descriptor output holds its value.
- R10: While descriptors are pending, `req_ready` is 0 and any request presented is ignored.
- R11: The first descriptor appears on the cycle after a legal request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Copy request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Request start address |
| req_count | input | CNT_W | Request byte count |
| req_err | output | 1 | One-cycle pulse for an illegal request |
| seg_valid | output | 1 | Descriptor present |
| seg_ready | input | 1 | Consumer takes the descriptor |
| seg_addr | output | ADDR_W | Descriptor start address |
| seg_count | output | CNT_W | Descriptor byte count |
| seg_size | output | 3 | Access size code, 2^code bytes |
| seg_last | output | 1 | Final descriptor of the request |

## Verification
The block's internal state is a running address plus three remaining piece lengths. If one of these is corrupted, the error shows up on the very next descriptor. The symptoms are a wrong address or count, a piece that is skipped or repeated, or a `seg_last` that appears too early or too late. Any of these breaks the contiguity of the descriptor chain, or makes the counts add up to something other than the request count. The bench sweeps every 4-byte-aligned offset within two 32-byte blocks against a range of counts, so each head, body and tail combination is compared descriptor by descriptor. A state that fails to clear after the final descriptor shows up one cycle later as a stuck `seg_valid` or a low `req_ready`.

// File: rtl/dma_align_splitter.sv
module dma_align_splitter #(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int BODY_LG  = 5,
  parameter int SMALL_LG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  output logic              req_err,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [CNT_W-1:0]  seg_count,
  output logic [2:0]        seg_size,
  output logic              seg_last
);

  localparam logic [BODY_LG-1:0] ONE_LO = {{(BODY_LG-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0]   LO_MASK = {{(CNT_W-BODY_LG){1'b0}}, {BODY_LG{1'b1}}};

  logic              busy;
  logic [ADDR_W-1:0] cur;
  logic [CNT_W-1:0]  hd, bd, tl;

  logic [BODY_LG-1:0] gap;
  logic [CNT_W-1:0]   gap_w, rest, hd_n, bd_n, tl_n;
  logic               fits, bad, take, fire, pick_h, pick_b;

  assign req_ready = !busy;
  assign take      = req_valid && !busy;
  assign bad       = (|req_addr[SMALL_LG-1:0]) || (|req_count[SMALL_LG-1:0]) || (req_count == '0);

  assign gap   = ~req_addr[BODY_LG-1:0] + ONE_LO;
  assign gap_w = {{(CNT_W-BODY_LG){1'b0}}, gap};
  assign fits  = req_count <= gap_w;
  assign rest  = req_count - gap_w;
  assign hd_n  = fits ? req_count : gap_w;
  assign bd_n  = fits ? '0 : (rest & ~LO_MASK);
  assign tl_n  = fits ? '0 : (rest & LO_MASK);

  assign pick_h    = hd != '0;
  assign pick_b    = !pick_h && (bd != '0);
  assign seg_valid = busy;
  assign seg_addr  = cur;
  assign seg_count = pick_h ? hd : (pick_b ? bd : tl);
  assign seg_size  = pick_b ? 3'(BODY_LG) : 3'(SMALL_LG);
  assign seg_last  = pick_h ? (bd == '0 && tl == '0) : (pick_b ? (tl == '0) : 1'b1);
  assign fire      = busy && seg_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      req_err <= 1'b0;
      cur     <= '0;
      hd      <= '0;
      bd      <= '0;
      tl      <= '0;
    end else begin
      req_err <= take && bad;
      if (take && !bad) begin
        busy <= 1'b1;
        cur  <= req_addr;
        hd   <= hd_n;
        bd   <= bd_n;
        tl   <= tl_n;
      end else if (fire) begin
        if (pick_h)      hd <= '0;
        else if (pick_b) bd <= '0;
        else             tl <= '0;
        cur <= cur + {{(ADDR_W-CNT_W){1'b0}}, seg_count};
        if (seg_last) busy <= 1'b0;
      end
    end
  end

  a_r2_err_no_seg: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !seg_valid && req_ready);
  a_r4_body_shape: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && seg_size == 3'(BODY_LG) |-> seg_addr[BODY_LG-1:0] == '0 && seg_count[BODY_LG-1:0] == '0 && seg_count != '0);
  a_r5_small_shape: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && seg_size == 3'(SMALL_LG) |-> seg_count != '0 && seg_count < CNT_W'(1 << BODY_LG) && seg_addr[SMALL_LG-1:0] == '0);
  a_r7_done: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && seg_ready && seg_last |=> !seg_valid && req_ready);
  a_r8_contig: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && seg_ready && !seg_last |=> seg_valid && seg_addr == $past(seg_addr) + {{(ADDR_W-CNT_W){1'b0}}, $past(seg_count)});
  a_r9_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_count));
  a_r9_hold_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> $stable(seg_size) && $stable(seg_last));
  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> !req_ready);

endmodule

// File: tb/dma_align_splitter_test.sv
module dma_align_splitter_test;
  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [31:0] req_addr = 0;
  logic [15:0] req_count = 0;
  logic req_err, seg_valid, seg_last;
  logic seg_ready = 0;
  logic [31:0] seg_addr;
  logic [15:0] seg_count;
  logic [2:0] seg_size;

  int vecs = 0, bad = 0, stall_ctr = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_align_splitter uut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_req(input int a, input int c, input bit poke);
    int ea[3]; int ec[3]; int es[3]; int n; int head; int rest; int idx; bit illegal;
    illegal = (a % 4 != 0) || (c % 4 != 0) || (c == 0);
    head = (32 - (a % 32)) % 32;
    n = 0;
    if (!illegal) begin
      if (c <= head) begin ea[0] = a; ec[0] = c; es[0] = 2; n = 1; end
      else begin
        if (head != 0) begin ea[n] = a; ec[n] = head; es[n] = 2; n++; end
        rest = c - head;
        if (rest / 32 != 0) begin ea[n] = a + head; ec[n] = (rest / 32) * 32; es[n] = 5; n++; end
        if (rest % 32 != 0) begin ea[n] = a + head + (rest / 32) * 32; ec[n] = rest % 32; es[n] = 2; n++; end
      end
    end
    chk(req_ready == 1, "R7 ready before request", req_ready, 1);
    req_valid = 1; req_addr = a; req_count = c;
    @(negedge clk);
    req_valid = 0;
    if (illegal) begin
      chk(req_err == 1 && seg_valid == 0, "R2 err pulse", {req_err, seg_valid}, 2);
      @(negedge clk);
      chk(req_err == 0 && seg_valid == 0 && req_ready == 1, "R2 err one cycle", {req_err, seg_valid, req_ready}, 1);
      return;
    end
    chk(seg_valid == 1, "R11 first descriptor next cycle", seg_valid, 1);
    idx = 0;
    while (idx < n) begin
      stall_ctr++;
      if (stall_ctr % 3 == 0) begin
        seg_ready = 0;
        if (poke) begin req_valid = 1; req_addr = 32'h40; req_count = 16'd64; end
        chk(req_ready == 0, "R10 busy not ready", req_ready, 0);
        @(negedge clk);
        req_valid = 0;
      end else begin
        chk(seg_valid == 1, "R9 valid held", seg_valid, 1);
        chk(int'(seg_addr) == ea[idx], "R8 address", seg_addr, ea[idx]);
        chk(int'(seg_count) == ec[idx], (es[idx] == 5) ? "R4 body count" : "R3 R5 R6 small count", seg_count, ec[idx]);
        chk(int'(seg_size) == es[idx], "R3 R4 R5 size code", seg_size, es[idx]);
        chk(seg_last == (idx == n - 1), "R7 last flag", seg_last, idx == n - 1);
        seg_ready = 1;
        @(negedge clk);
        seg_ready = 0;
        idx++;
      end
    end
    chk(seg_valid == 0 && req_ready == 1, "R7 idle after last", {seg_valid, req_ready}, 1);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk(seg_valid == 0 && req_err == 0 && req_ready == 1, "R1 reset state", {seg_valid, req_err, req_ready}, 1);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 64; a += 4)
      for (int c = 4; c <= 200; c += 4)
        run_req(32'h1000 + a, c, (c % 8) == 0);
    for (int a = 0; a < 64; a += 4) run_req(32'h8000 + a, 20000, 1);
    for (int k = 0; k < 4; k++) run_req(32'h1004 + k * 32, 4, 0);
    run_req(32'h1001, 64, 0);
    run_req(32'h1002, 8, 0);
    run_req(32'h1000, 62, 0);
    run_req(32'h1000, 0, 0);
    run_req(32'h1010, 64, 1);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vecs++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule